// File: doc/BRIEF.md
# I2C Bus-Clear Recovery Sequencer

This block takes the clock and data lines of an I2C port away from the transfer engine when a slave has been left holding data low. It then toggles the lines as general-purpose pins until the slave lets go. Software can drive the two pins by hand through a small register file. Alternatively, it can write one command bit and let a hardware sequencer do the job. The sequencer clocks the bus up to a fixed number of times and finishes with a STOP. While it runs, the engine is held in reset and interrupts are masked. When it is done, the pins go back to the engine and status bits report the result.

The pads are open-drain. The block never drives a line high. An output at level 1 releases the line, and the external pull-up raises it. The data-in register always shows the real wire level after a synchroniser, so another device holding the wire low is visible.

Top module: `i2c_bus_clear`

## Requirements
- R1: After reset, the function-select, direction and status registers read 0. Data-in reads 2'b11 with the bus idle. Neither pad is pulled low. The engine-hold and interrupt-mask outputs are 0.
- R2: Register addresses are: function-select 0, direction 1, set 2, clear 3, data-in 4, control/status 5. With function-select bit 0 set, both pads follow the general-purpose registers and the engine's drive inputs are ignored. With it clear, each pad follows the engine's drive-low input.
- R3: In the direction register, bit 0 makes SCL an output and bit 1 makes SDA an output. A pin set as input is released. A pin set as output is pulled low only while its level bit is 0.
- R4: Writing a 1 to bit 0 of the set register raises the SCL level bit, and a 1 to bit 1 raises the SDA level bit. The clear register lowers the same bits. A 0 written to either register leaves that level bit unchanged.
- R5: Data-in bit 0 is the SCL wire level and bit 1 is the SDA wire level. Both pass through a SYNC_STAGES-deep synchroniser, so a read shows the wire as it was SYNC_STAGES cycles earlier.
- R6: Writing bit 0 of control starts recovery. While busy (status bit 0), the block holds the engine in reset, masks interrupts, reads function-select as 1, drives SCL as an output and leaves SDA an input.
- R7: Each SCL low phase and each SCL high phase lasts exactly TICK_CYCLES clocks. SDA is sampled at the end of every high phase. The pulse loop stops at the first sample that reads high, and never runs more than MAX_PULSES pulses.
- R8: After the pulses, the sequencer pulls SCL and SDA low together for one phase, then releases SCL for one phase. It then releases SDA with SCL high for one phase, which forms a STOP condition.
- R9: At the end of the sequence, function-select and direction return to 0 and the engine hold and interrupt mask are released. Status then reads done in bit 1 with busy clear. The fail bit (bit 2) is set only when SDA still read low after pulse MAX_PULSES.
- R10: While busy, a further start command and all writes to function-select, direction, set and clear have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register address |
| regWdata | input | DATA_W | Register write data |
| regRdata | output | DATA_W | Register read data (combinational on regAddr) |
| engSclLow | input | 1 | Transfer engine wants SCL pulled low |
| engSdaLow | input | 1 | Transfer engine wants SDA pulled low |
| sclIn | input | 1 | SCL wire level |
| sdaIn | input | 1 | SDA wire level |
| sclDriveLow | output | 1 | Open-drain pull-down enable for SCL |
| sdaDriveLow | output | 1 | Open-drain pull-down enable for SDA |
| engHoldRst | output | 1 | Holds the transfer engine in reset |
| irqMask | output | 1 | Masks the port's interrupts |

## Verification
Software register writes and the sequencer's own control of the pins can land on the same cycle. The bench provokes this by writing function-select to 0 and issuing a second start in the middle of a run. It then judges the result by function-select still reading 1 and by the SCL falling-edge count staying at its expected value. The other overlap is a slave letting go of SDA during the final clock pulse, at the same moment the pulse budget runs out. The bench builds a slave model that releases on the ninth falling edge and expects a clean finish with fail clear, not a failure.

// File: rtl/i2c_bus_clear_pkg.sv
package i2c_bus_clear_pkg;
  localparam int A_FUNC = 0;
  localparam int A_DIR  = 1;
  localparam int A_SET  = 2;
  localparam int A_CLR  = 3;
  localparam int A_DIN  = 4;
  localparam int A_CTRL = 5;

  // strobes from the sequencer to the pin datapath
  typedef struct packed {
    logic enterGpio;
    logic exitGpio;
    logic sclSet;
    logic sclClr;
    logic sdaSet;
    logic sdaClr;
    logic sdaDrive;
  } seqStb_t;

  typedef enum logic [2:0] {
    S_IDLE, S_CLK_LO, S_CLK_HI, S_STOP_LO, S_STOP_HI, S_STOP_REL
  } seqState_t;
endpackage

// File: rtl/i2c_bus_clear_dp.sv
module i2c_bus_clear_dp
  import i2c_bus_clear_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  seqStb_t           stb,
  input  logic              busy,
  input  logic              doneFlag,
  input  logic              failFlag,
  input  logic              engSclLow,
  input  logic              engSdaLow,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic [DATA_W-1:0] regRdata,
  output logic              sclDriveLow,
  output logic              sdaDriveLow,
  output logic              engHoldRst,
  output logic              irqMask,
  output logic              funcSel,
  output logic              sdaLevel
);
  logic [1:0] dirReg;
  logic [1:0] lvlReg;
  logic       holdReg;
  logic [1:0] gpioLow;
  logic [1:0] pinSync;
  logic [1:0] syncPipe [SYNC_STAGES];
  logic       unusedW;

  assign unusedW = ^regWdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      funcSel <= 1'b0;
      dirReg  <= 2'b00;
      lvlReg  <= 2'b11;
      holdReg <= 1'b0;
    end else if (stb.enterGpio) begin
      funcSel <= 1'b1;
      dirReg  <= 2'b01;
      lvlReg  <= 2'b10;   // SCL low at once, SDA released
      holdReg <= 1'b1;
    end else if (stb.exitGpio) begin
      funcSel <= 1'b0;
      dirReg  <= 2'b00;
      lvlReg  <= 2'b11;
      holdReg <= 1'b0;
    end else begin
      if (regWr && !busy) begin
        case (regAddr)
          ADDR_W'(A_FUNC): funcSel <= regWdata[0];
          ADDR_W'(A_DIR):  dirReg  <= regWdata[1:0];
          ADDR_W'(A_SET):  lvlReg  <= lvlReg | regWdata[1:0];
          ADDR_W'(A_CLR):  lvlReg  <= lvlReg & ~regWdata[1:0];
          default: ;
        endcase
      end
      if (stb.sclSet)   lvlReg[0] <= 1'b1;
      if (stb.sclClr)   lvlReg[0] <= 1'b0;
      if (stb.sdaSet)   lvlReg[1] <= 1'b1;
      if (stb.sdaClr)   lvlReg[1] <= 1'b0;
      if (stb.sdaDrive) dirReg[1] <= 1'b1;
    end
  end

  // open-drain mux: only ever pull low
  assign gpioLow     = dirReg & ~lvlReg;
  assign sclDriveLow = funcSel ? gpioLow[0] : engSclLow;
  assign sdaDriveLow = funcSel ? gpioLow[1] : engSdaLow;
  assign engHoldRst  = holdReg;
  assign irqMask     = holdReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPipe[0] <= 2'b11;
    else       syncPipe[0] <= {sdaIn, sclIn};
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncPipe[s] <= 2'b11;
      else       syncPipe[s] <= syncPipe[s-1];
    end
  end

  assign pinSync  = syncPipe[SYNC_STAGES-1];
  assign sdaLevel = pinSync[1];

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_W'(A_FUNC): regRdata[0]   = funcSel;
      ADDR_W'(A_DIR):  regRdata[1:0] = dirReg;
      ADDR_W'(A_DIN):  regRdata[1:0] = pinSync;
      ADDR_W'(A_CTRL): regRdata[2:0] = {failFlag, doneFlag, busy};
      default: ;
    endcase
  end
endmodule

// File: rtl/i2c_bus_clear_ctrl.sv
module i2c_bus_clear_ctrl
  import i2c_bus_clear_pkg::*;
#(
  parameter int TICK_CYCLES = 1000,
  parameter int MAX_PULSES  = 9,
  localparam int CNT_W = $clog2(MAX_PULSES + 1),
  localparam int TW    = $clog2(TICK_CYCLES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             sdaLevel,
  output seqStb_t          stb,
  output logic             busy,
  output logic             doneFlag,
  output logic             failFlag,
  output logic             inPulse,
  output logic [CNT_W-1:0] pulseCnt
);
  localparam logic [TW-1:0]    TICK_LAST = TW'(TICK_CYCLES - 1);
  localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(MAX_PULSES - 1);

  seqState_t     state;
  logic [TW-1:0] timer;
  logic          phaseEnd;
  logic          lastPulse;

  assign phaseEnd  = (timer == '0);
  assign lastPulse = (pulseCnt == LAST_CNT);
  assign busy      = (state != S_IDLE);
  assign inPulse   = (state == S_CLK_LO) || (state == S_CLK_HI);

  always_comb begin
    stb = '0;
    case (state)
      S_IDLE:     stb.enterGpio = startReq;
      S_CLK_LO:   stb.sclSet    = phaseEnd;
      S_CLK_HI:   if (phaseEnd) begin
                    stb.sclClr = 1'b1;
                    if (sdaLevel || lastPulse) begin
                      stb.sdaClr   = 1'b1;
                      stb.sdaDrive = 1'b1;
                    end
                  end
      S_STOP_LO:  stb.sclSet    = phaseEnd;
      S_STOP_HI:  stb.sdaSet    = phaseEnd;
      S_STOP_REL: stb.exitGpio  = phaseEnd;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      timer    <= '0;
      pulseCnt <= '0;
      doneFlag <= 1'b0;
      failFlag <= 1'b0;
    end else if (state == S_IDLE) begin
      if (startReq) begin
        state    <= S_CLK_LO;
        timer    <= TICK_LAST;
        pulseCnt <= '0;
        doneFlag <= 1'b0;
        failFlag <= 1'b0;
      end
    end else if (!phaseEnd) begin
      timer <= timer - 1'b1;
    end else begin
      timer <= TICK_LAST;
      case (state)
        S_CLK_LO: state <= S_CLK_HI;
        S_CLK_HI: begin
          pulseCnt <= pulseCnt + 1'b1;
          if (sdaLevel) begin
            state <= S_STOP_LO;
          end else if (lastPulse) begin
            failFlag <= 1'b1;
            state    <= S_STOP_LO;
          end else begin
            state <= S_CLK_LO;
          end
        end
        S_STOP_LO: state <= S_STOP_HI;
        S_STOP_HI: state <= S_STOP_REL;
        default: begin
          state    <= S_IDLE;
          doneFlag <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/i2c_bus_clear.sv
module i2c_bus_clear
  import i2c_bus_clear_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 8,
  parameter int TICK_CYCLES = 1000,
  parameter int MAX_PULSES  = 9,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = $clog2(MAX_PULSES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              engSclLow,
  input  logic              engSdaLow,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclDriveLow,
  output logic              sdaDriveLow,
  output logic              engHoldRst,
  output logic              irqMask
);
  seqStb_t          stb;
  logic             busy;
  logic             doneFlag;
  logic             failFlag;
  logic             funcSel;
  logic             sdaLevel;
  logic             inPulse;
  logic             startReq;
  logic [CNT_W-1:0] pulseCnt;

  assign startReq = regWr && (regAddr == ADDR_W'(A_CTRL)) && regWdata[0];

  i2c_bus_clear_ctrl #(
    .TICK_CYCLES(TICK_CYCLES),
    .MAX_PULSES (MAX_PULSES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .sdaLevel(sdaLevel),
    .stb(stb), .busy(busy), .doneFlag(doneFlag), .failFlag(failFlag),
    .inPulse(inPulse), .pulseCnt(pulseCnt)
  );

  i2c_bus_clear_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .stb(stb), .busy(busy), .doneFlag(doneFlag),
    .failFlag(failFlag), .engSclLow(engSclLow), .engSdaLow(engSdaLow),
    .sclIn(sclIn), .sdaIn(sdaIn), .regRdata(regRdata),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow),
    .engHoldRst(engHoldRst), .irqMask(irqMask), .funcSel(funcSel),
    .sdaLevel(sdaLevel)
  );
endmodule

// File: rtl/i2c_bus_clear_chk.sv
module i2c_bus_clear_chk #(
  parameter int MAX_PULSES = 9,
  parameter int CNT_W      = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             funcSel,
  input logic             engHoldRst,
  input logic             irqMask,
  input logic             doneFlag,
  input logic             failFlag,
  input logic             sdaDriveLow,
  input logic             inPulse,
  input logic [CNT_W-1:0] pulseCnt
);
  p_hold_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (engHoldRst && irqMask && funcSel));

  p_sda_free_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    inPulse |-> !sdaDriveLow);

  p_pulse_cap_r7: assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt <= CNT_W'(MAX_PULSES));

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !doneFlag);

  p_fail_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    failFlag |-> (doneFlag || busy));

  p_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (!engHoldRst && !irqMask && !funcSel));
endmodule

bind i2c_bus_clear i2c_bus_clear_chk #(
  .MAX_PULSES(MAX_PULSES), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .funcSel(funcSel),
  .engHoldRst(engHoldRst), .irqMask(irqMask), .doneFlag(doneFlag),
  .failFlag(failFlag), .sdaDriveLow(sdaDriveLow), .inPulse(inPulse),
  .pulseCnt(pulseCnt)
);

// File: tb/i2c_bus_clear_bench.sv
module i2c_bus_clear_bench;
  localparam int TICK = 8;
  localparam int AW   = 3;
  localparam int DW   = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic          regWr = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [DW-1:0] regWdata = '0;
  logic [DW-1:0] regRdata;
  logic          engSclLow = 1'b0;
  logic          engSdaLow = 1'b0;
  logic          sclIn, sdaIn, sclDriveLow, sdaDriveLow, engHoldRst, irqMask;

  // slave model and bus monitor
  int   releaseAt = 0;
  logic clrMon = 1'b0;
  int   falls = 0, stops = 0, lowRun = 0, firstLow = 0;
  logic sclPrev = 1'b1, sdaPrev = 1'b1;
  logic slaveHold;

  assign slaveHold = (falls < releaseAt);
  assign sclIn = ~sclDriveLow;               // pull-up
  assign sdaIn = ~(sdaDriveLow | slaveHold); // pull-up, wired-AND

  always @(negedge clk) begin
    if (clrMon) begin
      falls <= 0; stops <= 0; lowRun <= 0; firstLow <= 0;
    end else begin
      if (sclPrev && !sclIn) falls <= falls + 1;
      if (sclPrev && sclIn && !sdaPrev && sdaIn) stops <= stops + 1;
      if (!sclIn) lowRun <= lowRun + 1;
      else begin
        if (!sclPrev && firstLow == 0) firstLow <= lowRun;
        lowRun <= 0;
      end
    end
    sclPrev <= sclIn;
    sdaPrev <= sdaIn;
  end

  i2c_bus_clear #(.ADDR_W(AW), .DATA_W(DW), .TICK_CYCLES(TICK),
                  .MAX_PULSES(9), .SYNC_STAGES(2)) u_i2c_bus_clear (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .engSclLow(engSclLow),
    .engSdaLow(engSdaLow), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow),
    .engHoldRst(engHoldRst), .irqMask(irqMask)
  );

  int nChecks = 0;
  int nFail = 0;

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    regWr = 1'b1; regAddr = AW'(a); regWdata = DW'(d);
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    regWr = 1'b0; regAddr = AW'(a);
    #1 d = int'(regRdata);
  endtask

  // fields: [10] func, [9:8] dir, [7:6] set, [5:4] clr,
  //         [3] engSclLow, [2] engSdaLow, [1:0] expected {sda,scl}
  localparam logic [10:0] VEC [10] = '{
    11'b0_00_00_00_0_0_11,
    11'b0_11_00_11_1_0_10,
    11'b1_11_00_00_1_1_00,
    11'b1_11_01_00_1_1_01,
    11'b1_01_00_00_0_0_11,
    11'b1_01_00_01_0_0_10,
    11'b1_10_00_00_0_0_01,
    11'b1_11_10_00_0_0_10,
    11'b1_11_11_00_0_0_11,
    11'b0_11_00_11_0_1_01
  };

  task automatic runRec(input int rel, input int expFalls, input int expStops,
                        input int expFail, input bit poke);
    int d;
    int waited;
    releaseAt = rel;
    @(negedge clk); clrMon = 1'b1;
    @(negedge clk); clrMon = 1'b0;
    wr(5, 1);
    repeat (2) @(negedge clk);
    chk("R6 engine hold", int'(engHoldRst), 1);
    chk("R6 irq mask", int'(irqMask), 1);
    rd(5, d); chk("R6 busy", d & 1, 1);
    rd(0, d); chk("R6 gpio mode", d, 1);
    if (poke) begin
      wr(0, 0);
      wr(5, 1);
      rd(0, d); chk("R10 func write while busy", d, 1);
    end
    waited = 0;
    do begin
      rd(5, d);
      waited++;
    end while ((d & 1) != 0 && waited < 4000);
    chk("R9 status", d, expFail != 0 ? 6 : 2);
    chk("R7 scl falls", falls, expFalls);
    chk("R8 stop seen", stops, expStops);
    chk("R7 low phase", firstLow, TICK);
    chk("R9 hold released", int'(engHoldRst) + int'(irqMask), 0);
    rd(0, d); chk("R9 func back", d, 0);
    rd(1, d); chk("R9 dir cleared", d, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    int d;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(0, d); chk("R1 func", d, 0);
    rd(1, d); chk("R1 dir", d, 0);
    rd(5, d); chk("R1 status", d, 0);
    rd(4, d); chk("R1 din", d, 3);
    chk("R1 drives", int'(sclDriveLow) + int'(sdaDriveLow), 0);
    chk("R1 hold/mask", int'(engHoldRst) + int'(irqMask), 0);

    // R2 R3 R4 R5 table
    for (int i = 0; i < 10; i++) begin
      engSclLow = VEC[i][3];
      engSdaLow = VEC[i][2];
      wr(0, int'(VEC[i][10]));
      wr(1, int'(VEC[i][9:8]));
      wr(2, int'(VEC[i][7:6]));
      wr(3, int'(VEC[i][5:4]));
      repeat (3) @(negedge clk);
      rd(4, d);
      chk($sformatf("R2/R3/R4/R5 vector %0d", i), d, int'(VEC[i][1:0]));
    end
    engSclLow = 1'b0;
    engSdaLow = 1'b0;

    // R7 R8 R9 R10 recovery runs
    runRec(3, 4, 1, 0, 1'b1);    // slave lets go on third pulse
    runRec(0, 2, 1, 0, 1'b0);    // bus already free: one pulse
    runRec(9, 10, 1, 0, 1'b0);   // release on the last allowed pulse
    runRec(255, 10, 0, 1, 1'b0); // stuck: fail set, no STOP visible
    releaseAt = 0;
    repeat (3) @(negedge clk);
    rd(4, d); chk("R5 bus idle after run", d, 3);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule